// File: doc/BRIEF.md
# Quadrature Position Counter with Coherent Byte Readout

This block turns a two-channel quadrature signal into a 16-bit signed-agnostic position count and lets a host with an 8-bit data path read that count. Every valid step of the two channels moves the count by one, up or down depending on which channel leads. A holding register sits between the live counter and the host bus. It normally copies the counter on every clock.

When the host starts a two-byte read by pulling the output enable low with the byte select low, the holding register stops following the counter. The host takes the high byte and then the low byte, and both bytes come from one frozen value while the counter keeps running underneath. Raising the output enable with the byte select high ends the read and lets the holding register follow again. A host that needs only the low byte can keep the byte select high all the time. In that case the freeze never engages and every read returns a fresh value.

Top module: `quad_snapshot_reader`

## Requirements
- R1: Reset clears the counter, the holding register and the freeze flag, so the first read after reset returns 0x00 for both bytes.
- R2: With channels encoded as {ch_a, ch_b}, each transition 00→10, 10→11, 11→01 or 01→00 adds one to the count.
- R3: Each transition in the reverse order (10→00, 11→10, 01→11, 00→01) subtracts one from the count.
- R4: A transition in which both channels change in the same sample leaves the count unchanged.
- R5: The count wraps modulo 2^16, so stepping down from 0x0000 gives 0xFFFF.
- R6: With oe_n low, sel low places bits 15:8 of the holding register on bus_data and sel high places bits 7:0.
- R7: While oe_n is high, bus_drive is low and bus_data is 0x00.
- R8: oe_n and sel are sampled on the falling clock edge. A sample of oe_n low with sel low freezes the holding register. A single long oe_n low pulse, with sel going from low to high, returns the high and low bytes of the count at the start of the read, even if the channels step during the read.
- R9: Two separate oe_n low pulses, the first with sel low and the second with sel high, return the high and low bytes of one snapshot, even if the channels step between and during the pulses.
- R10: The counter keeps counting while the holding register is frozen. After a falling-edge sample of oe_n high with sel high, the holding register again follows the counter, and a following read shows every step taken during the freeze.
- R11: With sel held high, reads never freeze the holding register. While oe_n stays low, the low byte tracks the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; counting on the rising edge, read controls sampled on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_a | input | 1 | Quadrature channel A, already synchronous to clk |
| ch_b | input | 1 | Quadrature channel B, already synchronous to clk |
| oe_n | input | 1 | Active-low output enable for the byte bus |
| sel | input | 1 | Byte select: low picks the high byte, high picks the low byte |
| bus_data | output | 8 | Selected byte of the holding register, zero when not driven |
| bus_drive | output | 1 | Tri-state enable for bus_data, high while oe_n is low |

## Verification
If the freeze flag sets or clears at the wrong moment, the holding register moves during a read. The two bytes of one read then disagree with any single count, and this shows up in the very byte the host takes after a channel step reaches the counter, about three clocks after the step. If the flag sticks set, every later read returns a stale value, and the next read after the counter moves exposes it. Decoder errors (wrong direction, counting an illegal double change, missing wrap) appear as a wrong value in the next settled read after the stimulus, three clocks after the channel change.

// File: rtl/qsr_pkg.sv
package qsr_pkg;

   // Direction of one decoded quadrature step
   typedef enum logic [1:0] {
      STEP_NONE = 2'b00,
      STEP_UP   = 2'b01,
      STEP_DOWN = 2'b10
   } qsr_step_e;

endpackage

// File: rtl/qsr_quad_decoder.sv
module qsr_quad_decoder
   import qsr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ch_a,
   input  logic      ch_b,
   output logic [1:0] ab_now,
   output logic [1:0] ab_old,
   output qsr_step_e step
);

   // Two sample stages: current channel pair and the one before it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ab_now <= 2'b00;
         ab_old <= 2'b00;
      end else begin
         ab_now <= {ch_a, ch_b};
         ab_old <= ab_now;
      end
   end

   // x4 decode: every legal Gray-code edge is one count
   always_comb begin
      unique case ({ab_old, ab_now})
         4'b0010, 4'b1011, 4'b1101, 4'b0100: step = STEP_UP;
         4'b1000, 4'b1110, 4'b0111, 4'b0001: step = STEP_DOWN;
         default:                             step = STEP_NONE;
      endcase
   end

   // A legal step never changes both channels at once
   AST_STEP_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (step != STEP_NONE) |-> ($countones(ab_now ^ ab_old) == 1)); // R4

endmodule

// File: rtl/qsr_updown.sv
module qsr_updown
   import qsr_pkg::*;
#(
   parameter int unsigned WIDTH = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  qsr_step_e        step,
   output logic [WIDTH-1:0] count
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         unique case (step)
            STEP_UP:   count <= count + ONE;
            STEP_DOWN: count <= count - ONE;
            default:   count <= count;
         endcase
      end
   end

   // The count moves by at most one per clock, modulo 2^WIDTH
   AST_UNIT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (count == $past(count)) || (count == $past(count) + ONE)
      || (count == $past(count) - ONE)); // R5

endmodule

// File: rtl/qsr_read_inhibit.sv
module qsr_read_inhibit (
   input  logic clk,
   input  logic rst_n,
   input  logic oe_n,
   input  logic sel,
   output logic frozen
);

   // Read controls are taken on the falling edge of clk
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frozen <= 1'b0;
      end else if (!oe_n && !sel) begin
         frozen <= 1'b1;
      end else if (oe_n && sel) begin
         frozen <= 1'b0;
      end
   end

   // Holding sel high never starts a freeze
   AST_SINGLE_BYTE_NO_FREEZE: assert property (@(negedge clk) disable iff (!rst_n)
      sel |=> !$rose(frozen)); // R11

   // A freeze survives the gap between two short read pulses
   AST_FREEZE_HOLDS_IN_GAP: assert property (@(negedge clk) disable iff (!rst_n)
      (frozen && !sel) |=> frozen); // R9

endmodule

// File: rtl/qsr_byte_select.sv
module qsr_byte_select #(
   parameter int unsigned BUS_W = 8
)(
   input  logic [2*BUS_W-1:0] word,
   input  logic               oe_n,
   input  logic               sel,
   output logic [BUS_W-1:0]   bus_data,
   output logic               bus_drive
);

   logic [BUS_W-1:0] picked;

   // Bitwise byte steering: sel low takes the upper half
   for (genvar i = 0; i < BUS_W; i++) begin : g_bit
      assign picked[i] = sel ? word[i] : word[BUS_W + i];
   end

   assign bus_drive = !oe_n;
   assign bus_data  = bus_drive ? picked : '0;

endmodule

// File: rtl/quad_snapshot_reader.sv
module quad_snapshot_reader
   import qsr_pkg::*;
#(
   parameter int unsigned BUS_W   = 8,
   parameter int unsigned COUNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ch_a,
   input  logic             ch_b,
   input  logic             oe_n,
   input  logic             sel,
   output logic [BUS_W-1:0] bus_data,
   output logic             bus_drive
);

   localparam int unsigned BYTES = COUNT_W / BUS_W;

   // Elaboration-time parameter checks
   if (BUS_W < 1) begin : g_bad_bus
      $error("quad_snapshot_reader: BUS_W must be at least 1");
   end
   if (BYTES != 2 || COUNT_W % BUS_W != 0) begin : g_bad_split
      $error("quad_snapshot_reader: COUNT_W must equal two bus widths");
   end

   logic [1:0]         ab_now;
   logic [1:0]         ab_old;
   qsr_step_e          step;
   logic [COUNT_W-1:0] count;
   logic [COUNT_W-1:0] hold_q;
   logic               frozen;

   qsr_quad_decoder u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .ch_a   (ch_a),
      .ch_b   (ch_b),
      .ab_now (ab_now),
      .ab_old (ab_old),
      .step   (step)
   );

   qsr_updown #(.WIDTH(COUNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .count (count)
   );

   qsr_read_inhibit u_inh (
      .clk    (clk),
      .rst_n  (rst_n),
      .oe_n   (oe_n),
      .sel    (sel),
      .frozen (frozen)
   );

   // Holding register: tracks the counter unless a read is in progress
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (!frozen) begin
         hold_q <= count;
      end
   end

   qsr_byte_select #(.BUS_W(BUS_W)) u_sel (
      .word      (hold_q),
      .oe_n      (oe_n),
      .sel       (sel),
      .bus_data  (bus_data),
      .bus_drive (bus_drive)
   );

   AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      frozen |=> $stable(hold_q)); // R8

   AST_HOLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !frozen |=> (hold_q == $past(count))); // R10

   AST_DOUBLE_CHANGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      ((ab_now ^ ab_old) == 2'b11) |=> $stable(count)); // R4

   AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!bus_drive && bus_data == '0)); // R7

endmodule

// File: tb/quad_snapshot_reader_tb.sv
module quad_snapshot_reader_tb;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n;
   logic       ch_a;
   logic       ch_b;
   logic       oe_n;
   logic       sel;
   logic [7:0] bus_data;
   logic       bus_drive;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [15:0] model_cnt;
   logic [7:0]  exp_q[$];
   string       tag_q[$];
   logic        mon_en = 1'b0;
   logic [7:0]  mon_exp;
   string       mon_tag;

   quad_snapshot_reader u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ch_a      (ch_a),
      .ch_b      (ch_b),
      .oe_n      (oe_n),
      .sel       (sel),
      .bus_data  (bus_data),
      .bus_drive (bus_drive)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Monitor: pops one expected byte per strobed falling edge
   always @(negedge clk) begin
      if (mon_en) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "scoreboard-empty", 0, 1);
         end else begin
            mon_exp = exp_q.pop_front();
            mon_tag = tag_q.pop_front();
            check(bus_drive && (bus_data == mon_exp), mon_tag,
                  {bus_drive, bus_data}, {1'b1, mon_exp});
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
      mon_en = 1'b0;
   endtask

   task automatic expect_byte(input logic [7:0] v, input string tag);
      exp_q.push_back(v);
      tag_q.push_back(tag);
      mon_en = 1'b1;
   endtask

   // One legal quadrature edge; up order 00->10->11->01->00
   task automatic qstep(input bit up);
      logic [1:0] ab;
      ab = {ch_a, ch_b};
      if (up) begin
         case (ab)
            2'b00: ab = 2'b10;
            2'b10: ab = 2'b11;
            2'b11: ab = 2'b01;
            default: ab = 2'b00;
         endcase
         model_cnt = model_cnt + 16'd1;
      end else begin
         case (ab)
            2'b10: ab = 2'b00;
            2'b11: ab = 2'b10;
            2'b01: ab = 2'b11;
            default: ab = 2'b01;
         endcase
         model_cnt = model_cnt - 16'd1;
      end
      {ch_a, ch_b} = ab;
   endtask

   task automatic run(input bit up, input int n);
      for (int i = 0; i < n; i++) begin
         qstep(up);
         tick();
      end
   endtask

   task automatic settle();
      repeat (4) tick();
   endtask

   // Settled two-pulse read of the current model value
   task automatic read_word(input string tag);
      logic [15:0] v;
      v = model_cnt;
      oe_n = 1'b0; sel = 1'b0;
      expect_byte(v[15:8], {tag, " high byte (R6)"});
      tick();
      oe_n = 1'b1;
      tick();
      oe_n = 1'b0; sel = 1'b1;
      expect_byte(v[7:0], {tag, " low byte (R6)"});
      tick();
      oe_n = 1'b1;
      tick();
      tick();
   endtask

   task automatic check_idle(input string tag);
      @(negedge clk);
      check(!bus_drive && bus_data == 8'h00, tag, {bus_drive, bus_data}, 0);
      tick();
   endtask

   initial begin
      logic [15:0] snap;
      rst_n = 1'b0; ch_a = 1'b0; ch_b = 1'b0; oe_n = 1'b1; sel = 1'b1;
      model_cnt = 16'h0000;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();

      // R1: reset state read back
      read_word("R1 reset");
      check_idle("R7 bus idle after reset");

      // R2 and R6: 300 up steps give 0x012C
      run(1'b1, 300);
      settle();
      read_word("R2 count up");

      // R3: 5 down steps
      run(1'b0, 5);
      settle();
      read_word("R3 count down");

      // R4: jump 00->11 style double change, then legal steps from there
      {ch_a, ch_b} = ~{ch_a, ch_b};
      tick();
      settle();
      read_word("R4 double change");
      run(1'b1, 2);
      settle();
      read_word("R4 legal after double change");

      // R5: wrap below zero
      run(1'b0, 301);
      settle();
      read_word("R5 wrap");
      run(1'b1, 0);

      // R8: one long OE pulse with counting during the read
      run(1'b1, 20);
      settle();
      snap = model_cnt;
      oe_n = 1'b0; sel = 1'b0;
      expect_byte(snap[15:8], "R8 long pulse high byte");
      tick();
      qstep(1'b1); tick();
      qstep(1'b1); tick();
      qstep(1'b1); tick();
      tick();
      tick();
      sel = 1'b1;
      expect_byte(snap[7:0], "R8 long pulse low byte");
      tick();
      oe_n = 1'b1;
      tick();
      settle();
      read_word("R10 steps during long read");

      // R9: two short pulses with counting in the gap
      snap = model_cnt;
      oe_n = 1'b0; sel = 1'b0;
      expect_byte(snap[15:8], "R9 short pulse high byte");
      tick();
      oe_n = 1'b1;
      qstep(1'b0); tick();
      qstep(1'b0); tick();
      qstep(1'b0); tick();
      tick();
      tick();
      oe_n = 1'b0; sel = 1'b1;
      expect_byte(snap[7:0], "R9 short pulse low byte");
      tick();
      oe_n = 1'b1;
      tick();
      check_idle("R7 bus idle between reads");
      settle();
      read_word("R10 steps during short reads");

      // R11: sel held high, OE held low, latch keeps following
      sel = 1'b1; oe_n = 1'b0;
      tick();
      run(1'b1, 5);
      settle();
      expect_byte(model_cnt[7:0], "R11 single-byte tracks count");
      tick();
      run(1'b1, 3);
      settle();
      expect_byte(model_cnt[7:0], "R11 single-byte tracks again");
      tick();
      oe_n = 1'b1;
      tick();

      // R1: reset from a nonzero count
      ch_a = 1'b0; ch_b = 1'b0;
      rst_n = 1'b0;
      tick();
      tick();
      rst_n = 1'b1;
      model_cnt = 16'h0000;
      tick();
      read_word("R1 reset after counting");

      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         check(1'b0, "watchdog", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule